// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves incoming packets into host memory through a ring of two-word receive descriptors. Software places a ring of descriptors in memory, hands each one to the block by setting its ownership flag, and programs two registers: the ring base address and the pointer to the next descriptor the block will use. Packets arrive as a stream of big-endian 32-bit beats. The block fetches the current descriptor, copies packet words into the buffer that the descriptor names, and moves to further descriptors when a buffer fills. It then writes a status word back for each descriptor it used.

A packet can span several chained descriptors. The status of the first descriptor in the chain is held back until every later descriptor has been updated. Only then is it written, and a one-cycle interrupt request follows. Software therefore never sees a partly written chain through its head entry. The final length reported includes a CRC allowance that is set by an input. The block does not generate or check any CRC itself. All memory traffic goes through a single master port that carries one word transaction at a time.

Top module: `rxring_writer`

## Requirements
- R1: While reset is high and one cycle after it, the block issues no memory request, keeps `irq` and `in_ready` low, and both registers read back as zero.
- R2: The ring base is at offset 0x04 and the current pointer is at offset 0x08. Both can be written and read. Read data appears on `reg_rdata` one cycle after `reg_rd`. Any other offset reads as zero.
- R3: While the ring base register is zero, every beat of an arriving packet is consumed. No memory request is made and no interrupt is raised.
- R4: Word 0 of a descriptor has its ownership flag in bit 31. If that bit is clear when a packet arrives, the packet is consumed and nothing is written. The current pointer keeps its value and no interrupt is raised.
- R5: Each beat is written as one word to the buffer address (descriptor word 1) plus the byte offset inside that buffer. Packet byte 0 sits in bits 31:24. On the last beat only the `in_nbytes` leading bytes are enabled: `mem_be` bit 3 enables bits 31:24 and bit 0 enables bits 7:0.
- R6: Word 0 of the descriptor that completes the packet is written with the bytes stored in it plus `crc_bytes`. Every other bit is zero, including the ownership flag.
- R7: A buffer holds word 0 bits 12:2 times four bytes; bits 1:0 of the length field are ignored. When a buffer is full and the packet goes on, the block reads word 0 of the next descriptor. If that descriptor is owned, the block writes bit 27 (continue) together with the stored byte count into the full descriptor and keeps going.
- R8: The descriptor after one at address A is the ring base if bit 30 of A's word 0 is set, and A+8 otherwise. After a packet, the current pointer names the descriptor after the last one used.
- R9: If the next descriptor is not owned, the full descriptor gets the byte count alone with bit 27 clear. The rest of the packet is consumed and discarded, and the current pointer names the unowned descriptor.
- R10: The status write to the chain's first descriptor is the last memory write of the packet. `irq` is high for exactly one cycle right after it is acknowledged.
- R11: Only the first 8192 bytes of a packet are stored. Beats beyond that are consumed without any memory access.
- R12: A memory request keeps its address, direction, data and byte enables until `mem_ack` is seen. While a request is pending, no beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, registered |
| crc_bytes | input | 3 | CRC allowance added to the final length |
| in_valid | input | 1 | Packet beat valid |
| in_ready | output | 1 | Packet beat accepted when high with in_valid |
| in_data | input | 32 | Packet beat, big-endian |
| in_last | input | 1 | Last beat of the packet |
| in_nbytes | input | 3 | Valid bytes in the last beat (1 to 4) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Write byte enables, bit 3 for bits 31:24 |
| mem_ack | input | 1 | Memory request completed |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| irq | output | 1 | One-cycle interrupt request per stored packet |

## Verification
The packets used are a single short packet with a partial last word that fits one buffer, a packet that chains through three descriptors ending on a wrapping entry, a packet that runs into an unowned second descriptor, and an 8200-byte packet against two 4096-byte buffers. Together they separate the final status (count plus CRC) from the link status (continue plus count) and the stop status (count alone), and show where the current pointer goes after a wrap and after a stop. Packets sent with the ring disabled or with an unowned head descriptor must leave memory, the pointer and the interrupt untouched. The chained case runs with a stalling memory to show that requests hold steady and that the head status is written last.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int WORD_W   = 32;
  localparam int OWN_BIT  = 31;
  localparam int WRAP_BIT = 30;
  localparam int CONT_BIT = 27;
  localparam int LEN_MSB  = 12;
  localparam int DESC_BYTES = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_W0,
    ST_RD_W1,
    ST_FILL,
    ST_WR_DATA,
    ST_RD_NEXT,
    ST_WR_STAT,
    ST_WR_FIRST,
    ST_DROP
  } eng_state_t;

  typedef struct packed {
    logic              req;
    logic              we;
    logic [WORD_W-1:0] addr;
    logic [WORD_W-1:0] wdata;
    logic [3:0]        be;
  } mem_cmd_t;
endpackage

// File: rtl/rxr_regs.sv
module rxr_regs #(
  parameter int REG_AW    = 8,
  parameter int OFS_START = 4,
  parameter int OFS_CUR   = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      reg_wr,
  input  logic                      reg_rd,
  input  logic [REG_AW-1:0]         reg_addr,
  input  logic [rxr_pkg::WORD_W-1:0] reg_wdata,
  output logic [rxr_pkg::WORD_W-1:0] reg_rdata,
  input  logic                      cur_we,
  input  logic [rxr_pkg::WORD_W-1:0] cur_wdata,
  output logic [rxr_pkg::WORD_W-1:0] start_addr,
  output logic [rxr_pkg::WORD_W-1:0] cur_addr
);
  localparam logic [REG_AW-1:0] A_START = REG_AW'(OFS_START);
  localparam logic [REG_AW-1:0] A_CUR   = REG_AW'(OFS_CUR);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_addr <= '0;
      cur_addr   <= '0;
      reg_rdata  <= '0;
    end else begin
      if (reg_wr && reg_addr == A_START) start_addr <= reg_wdata;
      if (cur_we)
        cur_addr <= cur_wdata;
      else if (reg_wr && reg_addr == A_CUR)
        cur_addr <= reg_wdata;
      if (reg_rd) begin
        if (reg_addr == A_START)    reg_rdata <= start_addr;
        else if (reg_addr == A_CUR) reg_rdata <= cur_addr;
        else                        reg_rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/rxr_beat_lanes.sv
module rxr_beat_lanes #(
  parameter int LANES = 4
) (
  input  logic                         last,
  input  logic [$clog2(LANES+1)-1:0]   nbytes,
  output logic [$clog2(LANES+1)-1:0]   count,
  output logic [LANES-1:0]             be
);
  localparam int NW = $clog2(LANES+1);

  always_comb begin
    if (last && nbytes != '0 && nbytes <= NW'(LANES)) count = nbytes;
    else                                              count = NW'(LANES);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be[LANES-1-i] = (NW'(i) < count);
  end
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine
  import rxr_pkg::*;
#(
  parameter int MAX_BYTES = 8192,
  parameter int CRC_W     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] start_addr,
  input  logic [WORD_W-1:0] cur_addr,
  input  logic [CRC_W-1:0]  crc_bytes,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_last,
  input  logic [2:0]        beat_n,
  input  logic [3:0]        beat_be,
  output logic              in_ready,
  output logic              cur_we,
  output logic [WORD_W-1:0] cur_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [3:0]        mem_be,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              irq
);
  localparam int CNT_W = $clog2(MAX_BYTES + 1);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_BYTES);

  eng_state_t        st;
  mem_cmd_t          cmd;
  logic [WORD_W-1:0] desc_addr, nxt_addr, buf_addr, first_addr, first_stat;
  logic [CNT_W-1:0]  cap, cnt, total;
  logic [2:0]        pend_n;
  logic              pend_last, is_first, wrap_f, drain_after, cont_after;

  logic              full;
  logic [CNT_W-1:0]  sum_cnt, sum_tot;
  logic [WORD_W-1:0] fin_stat, link_stat, next_of;
  logic              ack;

  function automatic mem_cmd_t rd_cmd(input logic [WORD_W-1:0] a);
    mem_cmd_t c;
    c.req = 1'b1; c.we = 1'b0; c.addr = a; c.wdata = '0; c.be = 4'hF;
    return c;
  endfunction

  function automatic mem_cmd_t wr_cmd(input logic [WORD_W-1:0] a,
                                      input logic [WORD_W-1:0] d,
                                      input logic [3:0] e);
    mem_cmd_t c;
    c.req = 1'b1; c.we = 1'b1; c.addr = a; c.wdata = d; c.be = e;
    return c;
  endfunction

  always_comb begin
    ack       = cmd.req && mem_ack;
    full      = (cnt >= cap);
    sum_cnt   = cnt + CNT_W'(pend_n);
    sum_tot   = total + CNT_W'(pend_n);
    fin_stat  = WORD_W'(sum_cnt) + WORD_W'(crc_bytes);
    link_stat = WORD_W'(cnt);
    link_stat[CONT_BIT] = mem_rdata[OWN_BIT];
    next_of   = wrap_f ? start_addr : desc_addr + WORD_W'(DESC_BYTES);
  end

  assign in_ready  = (st == ST_FILL && !full) || st == ST_DROP;
  assign mem_req   = cmd.req;
  assign mem_we    = cmd.we;
  assign mem_addr  = cmd.addr;
  assign mem_wdata = cmd.wdata;
  assign mem_be    = cmd.be;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      cmd         <= '0;
      desc_addr   <= '0;
      nxt_addr    <= '0;
      buf_addr    <= '0;
      first_addr  <= '0;
      first_stat  <= '0;
      cap         <= '0;
      cnt         <= '0;
      total       <= '0;
      pend_n      <= '0;
      pend_last   <= 1'b0;
      is_first    <= 1'b0;
      wrap_f      <= 1'b0;
      drain_after <= 1'b0;
      cont_after  <= 1'b0;
      cur_we      <= 1'b0;
      cur_wdata   <= '0;
      irq         <= 1'b0;
    end else begin
      irq    <= 1'b0;
      cur_we <= 1'b0;
      if (ack) cmd.req <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (in_valid) begin
            if (start_addr == '0) begin
              st <= ST_DROP;
            end else begin
              desc_addr   <= cur_addr;
              first_addr  <= cur_addr;
              is_first    <= 1'b1;
              total       <= '0;
              drain_after <= 1'b0;
              cmd         <= rd_cmd(cur_addr);
              st          <= ST_RD_W0;
            end
          end
        end
        ST_RD_W0: begin
          if (ack) begin
            if (!mem_rdata[OWN_BIT]) begin
              st <= ST_DROP;
            end else begin
              cap    <= CNT_W'({mem_rdata[LEN_MSB:2], 2'b00});
              wrap_f <= mem_rdata[WRAP_BIT];
              cmd    <= rd_cmd(desc_addr + WORD_W'(4));
              st     <= ST_RD_W1;
            end
          end
        end
        ST_RD_W1: begin
          if (ack) begin
            buf_addr <= mem_rdata;
            cnt      <= '0;
            st       <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (full) begin
            nxt_addr <= next_of;
            cmd      <= rd_cmd(next_of);
            st       <= ST_RD_NEXT;
          end else if (in_valid) begin
            pend_n    <= beat_n;
            pend_last <= in_last;
            cmd       <= wr_cmd(buf_addr + WORD_W'(cnt), in_data, beat_be);
            st        <= ST_WR_DATA;
          end
        end
        ST_WR_DATA: begin
          if (ack) begin
            cnt   <= sum_cnt;
            total <= sum_tot;
            if (pend_last || sum_tot == MAX_CNT) begin
              cur_we      <= 1'b1;
              cur_wdata   <= next_of;
              drain_after <= !pend_last;
              if (is_first) begin
                cmd <= wr_cmd(first_addr, fin_stat, 4'hF);
                st  <= ST_WR_FIRST;
              end else begin
                cont_after <= 1'b0;
                cmd        <= wr_cmd(desc_addr, fin_stat, 4'hF);
                st         <= ST_WR_STAT;
              end
            end else begin
              st <= ST_FILL;
            end
          end
        end
        ST_RD_NEXT: begin
          if (ack) begin
            cur_we    <= 1'b1;
            cur_wdata <= nxt_addr;
            cap       <= CNT_W'({mem_rdata[LEN_MSB:2], 2'b00});
            wrap_f    <= mem_rdata[WRAP_BIT];
            if (is_first) begin
              first_stat <= link_stat;
              if (mem_rdata[OWN_BIT]) begin
                desc_addr <= nxt_addr;
                is_first  <= 1'b0;
                cmd       <= rd_cmd(nxt_addr + WORD_W'(4));
                st        <= ST_RD_W1;
              end else begin
                drain_after <= 1'b1;
                cmd         <= wr_cmd(first_addr, link_stat, 4'hF);
                st          <= ST_WR_FIRST;
              end
            end else begin
              cont_after  <= mem_rdata[OWN_BIT];
              drain_after <= !mem_rdata[OWN_BIT];
              cmd         <= wr_cmd(desc_addr, link_stat, 4'hF);
              st          <= ST_WR_STAT;
            end
          end
        end
        ST_WR_STAT: begin
          if (ack) begin
            if (cont_after) begin
              desc_addr <= nxt_addr;
              cmd       <= rd_cmd(nxt_addr + WORD_W'(4));
              st        <= ST_RD_W1;
            end else begin
              cmd <= wr_cmd(first_addr, first_stat, 4'hF);
              st  <= ST_WR_FIRST;
            end
          end
        end
        ST_WR_FIRST: begin
          if (ack) begin
            irq <= 1'b1;
            st  <= drain_after ? ST_DROP : ST_IDLE;
          end
        end
        ST_DROP: begin
          if (in_valid && in_last) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer #(
  parameter int MAX_BYTES = 8192,
  parameter int REG_AW    = 8,
  parameter int CRC_W     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [CRC_W-1:0]  crc_bytes,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_data,
  input  logic              in_last,
  input  logic [2:0]        in_nbytes,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              irq
);
  logic [31:0] start_addr, cur_addr, cur_wdata;
  logic        cur_we;
  logic [2:0]  beat_n;
  logic [3:0]  beat_be;

  rxr_regs #(.REG_AW(REG_AW), .OFS_START(4), .OFS_CUR(8)) regs_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cur_we(cur_we), .cur_wdata(cur_wdata),
    .start_addr(start_addr), .cur_addr(cur_addr)
  );

  rxr_beat_lanes #(.LANES(4)) lanes_i (
    .last(in_last), .nbytes(in_nbytes), .count(beat_n), .be(beat_be)
  );

  rxr_engine #(.MAX_BYTES(MAX_BYTES), .CRC_W(CRC_W)) eng_i (
    .clk(clk), .rst(rst), .start_addr(start_addr), .cur_addr(cur_addr),
    .crc_bytes(crc_bytes), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .beat_n(beat_n), .beat_be(beat_be),
    .in_ready(in_ready), .cur_we(cur_we), .cur_wdata(cur_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .irq(irq)
  );
endmodule

// File: rtl/rxring_writer_chk.sv
module rxring_writer_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_ready,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic [3:0]  mem_be,
  input logic        mem_ack,
  input logic        irq
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!mem_req && !irq && !in_ready)); // R1

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata) && $stable(mem_be))); // R12

  AST_NO_BEAT_WHILE_PENDING: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !mem_req); // R12

  AST_WRITE_LANES: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_be != 4'b0000)); // R5

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R10

  AST_IRQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(mem_req && mem_ack && mem_we)); // R10
endmodule

bind rxring_writer rxring_writer_chk chk_i (.*);

// File: tb/rxring_writer_tb_top.sv
module rxring_writer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [2:0]  crc_bytes = 3'd2;
  logic        in_valid = 1'b0, in_ready, in_last = 1'b0;
  logic [31:0] in_data = '0;
  logic [2:0]  in_nbytes = 3'd4;
  logic        mem_req, mem_we, mem_ack = 1'b0, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [3:0]  mem_be;

  logic [31:0] mem [0:4095];
  int n_tests = 0, n_fail = 0;
  int wr_cnt = 0, req_cycles = 0, irq_cnt = 0, cyc = 0;
  logic [31:0] last_wr_addr = '0, wr_before_irq = '0;
  bit stall = 1'b0;

  always #2 clk = ~clk;

  rxring_writer dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .crc_bytes(crc_bytes),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .in_nbytes(in_nbytes), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  task automatic mem_service();
    forever begin
      @(negedge clk);
      cyc++;
      if (mem_req && !(stall && (cyc % 2 == 1))) begin
        mem_ack = 1'b1;
        mem_rdata = mem[mem_addr[13:2]];
        if (mem_we) begin
          for (int b = 0; b < 4; b++)
            if (mem_be[3-b]) mem[mem_addr[13:2]][31-8*b -: 8] = mem_wdata[31-8*b -: 8];
          wr_cnt++;
          last_wr_addr = mem_addr;
        end
      end else begin
        mem_ack = 1'b0;
      end
      if (mem_req) req_cycles++;
      if (irq) begin
        irq_cnt++;
        wr_before_irq = last_wr_addr;
      end
    end
  endtask

  task automatic watchdog();
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  endtask

  function automatic logic [31:0] pword(input int seed, input int w);
    logic [31:0] d;
    for (int b = 0; b < 4; b++) d[31-8*b -: 8] = 8'(seed + 4*w + b);
    return d;
  endfunction

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic send_pkt(input int nbytes, input int seed);
    int nw;
    nw = (nbytes + 3) / 4;
    @(negedge clk);
    for (int w = 0; w < nw; w++) begin
      in_valid  = 1'b1;
      in_data   = pword(seed, w);
      in_last   = (w == nw - 1);
      in_nbytes = (w == nw - 1) ? 3'(nbytes - 4*w) : 3'd4;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  task automatic set_desc(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1);
    mem[a[13:2]]     = w0;
    mem[a[13:2] + 1] = w1;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq after reset", {31'b0, irq}, 32'd0);
    chk("R1 mem_req after reset", {31'b0, mem_req}, 32'd0);
    chk("R1 in_ready after reset", {31'b0, in_ready}, 32'd0);
    reg_read(8'h04, v); chk("R1 base reg after reset", v, 32'd0);
    reg_read(8'h08, v); chk("R1 pointer reg after reset", v, 32'd0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    reg_write(8'h04, 32'h0000_0100);
    reg_write(8'h08, 32'h0000_0118);
    reg_read(8'h04, v); chk("R2 base readback", v, 32'h100);
    reg_read(8'h08, v); chk("R2 pointer readback", v, 32'h118);
    reg_read(8'h0C, v); chk("R2 other offset reads zero", v, 32'h0);
  endtask

  task automatic t_disabled();
    int r0, i0;
    logic [31:0] v;
    reg_write(8'h04, 32'h0);
    reg_write(8'h08, 32'h100);
    r0 = req_cycles; i0 = irq_cnt;
    send_pkt(12, 8'h30);
    chk("R3 no memory request", 32'(req_cycles - r0), 32'd0);
    chk("R3 no irq", 32'(irq_cnt - i0), 32'd0);
    reg_read(8'h08, v); chk("R3 pointer unchanged", v, 32'h100);
    reg_write(8'h04, 32'h100);
  endtask

  task automatic t_single();
    int i0;
    logic [31:0] v;
    for (int k = 0; k < 16; k++) mem[(32'h400 >> 2) + k] = 32'hAAAA_AAAA;
    set_desc(32'h100, 32'h8000_0040, 32'h400);
    reg_write(8'h08, 32'h100);
    crc_bytes = 3'd4;
    i0 = irq_cnt;
    send_pkt(10, 8'h10);
    chk("R5 word 0", mem[32'h400 >> 2], 32'h1011_1213);
    chk("R5 word 1", mem[32'h404 >> 2], 32'h1415_1617);
    chk("R5 partial last word", mem[32'h408 >> 2], 32'h1819_AAAA);
    chk("R5 beyond packet untouched", mem[32'h40C >> 2], 32'hAAAA_AAAA);
    chk("R6 final status count plus crc", mem[32'h100 >> 2], 32'd14);
    reg_read(8'h08, v); chk("R8 pointer advanced by 8", v, 32'h108);
    chk("R10 one irq", 32'(irq_cnt - i0), 32'd1);
  endtask

  task automatic t_not_owned();
    int w0, i0;
    logic [31:0] v;
    set_desc(32'h108, 32'h0000_0040, 32'h500);
    w0 = wr_cnt; i0 = irq_cnt;
    send_pkt(8, 8'h20);
    chk("R4 nothing written", 32'(wr_cnt - w0), 32'd0);
    chk("R4 no irq", 32'(irq_cnt - i0), 32'd0);
    reg_read(8'h08, v); chk("R4 pointer unchanged", v, 32'h108);
    chk("R4 descriptor untouched", mem[32'h108 >> 2], 32'h0000_0040);
  endtask

  task automatic t_chain();
    int i0;
    logic [31:0] v;
    for (int k = 0; k < 4; k++) mem[(32'h500 >> 2) + k] = 32'hAAAA_AAAA;
    set_desc(32'h108, 32'h8000_000B, 32'h500);
    set_desc(32'h110, 32'h8000_0008, 32'h600);
    set_desc(32'h118, 32'hC000_0040, 32'h700);
    crc_bytes = 3'd2;
    stall = 1'b1;
    i0 = irq_cnt;
    send_pkt(20, 8'h40);
    stall = 1'b0;
    chk("R7 first link status", mem[32'h108 >> 2], 32'h0800_0008);
    chk("R7 second link status", mem[32'h110 >> 2], 32'h0800_0008);
    chk("R7 low length bits ignored", mem[32'h508 >> 2], 32'hAAAA_AAAA);
    chk("R5 second buffer data", mem[32'h604 >> 2], pword(8'h40, 3));
    chk("R5 third buffer data", mem[32'h700 >> 2], pword(8'h40, 4));
    chk("R6 final status on wrap entry", mem[32'h118 >> 2], 32'd6);
    reg_read(8'h08, v); chk("R8 pointer wraps to base", v, 32'h100);
    chk("R10 head status written last", wr_before_irq, 32'h108);
    chk("R10 one irq for chain", 32'(irq_cnt - i0), 32'd1);
  endtask

  task automatic t_stop();
    int i0;
    logic [31:0] v;
    mem[32'h408 >> 2] = 32'hAAAA_AAAA;
    set_desc(32'h100, 32'h8000_0008, 32'h400);
    set_desc(32'h108, 32'h0000_0040, 32'h500);
    crc_bytes = 3'd4;
    reg_write(8'h08, 32'h100);
    i0 = irq_cnt;
    send_pkt(16, 8'h80);
    chk("R9 stop status count only", mem[32'h100 >> 2], 32'd8);
    chk("R9 unowned entry untouched", mem[32'h108 >> 2], 32'h0000_0040);
    chk("R9 data after stop not stored", mem[32'h408 >> 2], 32'hAAAA_AAAA);
    reg_read(8'h08, v); chk("R9 pointer at unowned entry", v, 32'h108);
    chk("R9 irq raised", 32'(irq_cnt - i0), 32'd1);
  endtask

  task automatic t_trunc();
    int i0;
    logic [31:0] v;
    mem[32'h3000 >> 2] = 32'hAAAA_AAAA;
    set_desc(32'h100, 32'h8000_1000, 32'h1000);
    set_desc(32'h108, 32'hC000_1000, 32'h2000);
    crc_bytes = 3'd2;
    reg_write(8'h08, 32'h100);
    i0 = irq_cnt;
    send_pkt(8200, 0);
    chk("R11 first buffer link status", mem[32'h100 >> 2], 32'h0800_1000);
    chk("R11 final status capped", mem[32'h108 >> 2], 32'h0000_1002);
    chk("R11 last stored word", mem[32'h2FFC >> 2], 32'hFCFD_FEFF);
    chk("R11 nothing past limit", mem[32'h3000 >> 2], 32'hAAAA_AAAA);
    reg_read(8'h08, v); chk("R11 pointer after wrap", v, 32'h100);
    chk("R11 one irq", 32'(irq_cnt - i0), 32'd1);
  endtask

  initial begin
    for (int k = 0; k < 4096; k++) mem[k] = '0;
    fork
      mem_service();
      watchdog();
    join_none
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_disabled();
    t_single();
    t_not_owned();
    t_chain();
    t_stop();
    t_trunc();
    summary();
    $finish;
  end
endmodule